// File: doc/BRIEF.md
# Periodic Millisecond Interrupt Timer

This block is a free-running interval timer that raises an interrupt every programmable whole number of milliseconds. A synchronous 1 kHz tick input (a one-cycle pulse per millisecond) advances an internal counter. When the counter has seen as many ticks as the period register holds, a sticky event flag is set and the counter starts again from zero. Counting and interrupt delivery each have their own enable, so software can keep the interval running while it masks the interrupt line.

Software reaches the block through a simple register bus with two word addresses: a status/control word at address 0 and a period word at address 1. In the status word, bit 15 enables counting, bit 14 enables the interrupt and bit 13 is the event flag. The flag is cleared by writing a one to bit 13. Writing a zero there leaves it alone, so the enable bits can be rewritten without losing a pending event. The interrupt output is a registered level that stays high while the flag and the interrupt enable are both set.

Top module: `pit_ms_timer`

## Requirements
- R1: After reset the status word (address 0) and the period word (address 1) both read as zero, and `irq_o` is low.
- R2: A write to address 1 stores the low PERIOD_W bits of `wdata_i`. A read of address 1 returns them zero-extended, and `rdata_o` is valid in the cycle after the cycle in which `rd_en_i` is high.
- R3: With count enable (status bit 15) set and a period of N, the event flag (status bit 13) sets on the Nth tick, and the counter restarts so that the next event comes N ticks later.
- R4: While status bit 15 is clear, ticks are ignored and the count holds its value. Counting resumes from that value once bit 15 is set again.
- R5: `irq_o` is high exactly when the event flag and the interrupt enable (status bit 14) are both set. A flag set with bit 14 clear leaves `irq_o` low until bit 14 is set.
- R6: Writing status with bit 13 set clears the event flag. Writing status with bit 13 clear leaves the flag unchanged and still updates bits 15 and 14.
- R7: Writing the period register restarts the count from zero, so the new interval is counted in full from that write.
- R8: A period of zero disables event generation: the flag never sets, whatever the ticks.
- R9: If a flag-clear write and a terminal tick fall in the same cycle, the flag ends up set.
- R10: A period of 1 sets the flag on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per millisecond, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word address (0 = status/control, 1 = period) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, valid one cycle after rd_en_i |
| irq_o | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The bench builds the block with its defaults: a 32-bit data word, a 2-bit address and a 16-bit period. This lets it read back an all-ones period and a write whose upper data bits must be dropped. Because short periods (1 and 4) cost only a few ticks, the bench can reach wrap-around, hold-while-disabled, restart-on-write, zero period and the same-cycle set/clear collision, all within a handful of ticks each.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // Status word bit positions (shared with a wider timekeeping peripheral)
  localparam int unsigned CE_BIT = 15;
  localparam int unsigned IE_BIT = 14;
  localparam int unsigned EV_BIT = 13;
  // Word addresses
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_PERIOD = 1;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                flag_i,
  output logic                cen_o,
  output logic                ien_o,
  output logic                ien_next_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                period_wr_o,
  output logic                clr_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic status_wr;
  logic cen_q, ien_q;
  logic [PERIOD_W-1:0] period_q;
  logic [DATA_W-1:0] rd_mux;

  assign status_wr   = wr_en_i && (addr_i == ADDR_W'(ADDR_STATUS));
  assign period_wr_o = wr_en_i && (addr_i == ADDR_W'(ADDR_PERIOD));
  assign clr_o       = status_wr && wdata_i[EV_BIT];
  assign ien_next_o  = status_wr ? wdata_i[IE_BIT] : ien_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cen_q    <= 1'b0;
      ien_q    <= 1'b0;
      period_q <= '0;
    end else begin
      if (status_wr) begin
        cen_q <= wdata_i[CE_BIT];
        ien_q <= wdata_i[IE_BIT];
      end
      if (period_wr_o) period_q <= wdata_i[PERIOD_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(ADDR_STATUS)) begin
      rd_mux[CE_BIT] = cen_q;
      rd_mux[IE_BIT] = ien_q;
      rd_mux[EV_BIT] = flag_i;
    end else if (addr_i == ADDR_W'(ADDR_PERIOD)) begin
      rd_mux[PERIOD_W-1:0] = period_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign cen_o    = cen_q;
  assign ien_o    = ien_q;
  assign period_o = period_q;

  // R2: a period write is visible in the stored period on the next cycle
  p_period_store_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    period_wr_o |=> (period_q == $past(wdata_i[PERIOD_W-1:0])));
endmodule

// File: rtl/pit_count.sv
module pit_count #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                tick_i,
  input  logic                cen_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                restart_i,
  output logic                hit_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic live, advance, at_end;

  assign live    = (period_i != '0);
  assign advance = tick_i && cen_i && live;
  assign at_end  = (cnt_q == period_i - PERIOD_W'(1));
  assign hit_o   = advance && at_end;

  always_ff @(posedge clk_i) begin
    if (rst_i)          cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (advance)   cnt_q <= at_end ? '0 : cnt_q + PERIOD_W'(1);
  end

  // R4: count holds while counting is disabled
  p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cen_i && !restart_i) |=> $stable(cnt_q));
  // R8: zero period never produces an event
  p_zero_period_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (period_i == '0) |-> !hit_o);
  // R3: the count stays below a nonzero period
  p_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (period_i != '0) |-> (cnt_q < period_i));
  // R7: a period write sends the count back to zero
  p_restart_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/pit_event.sv
module pit_event (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hit_i,
  input  logic clr_i,
  input  logic ien_next_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_next;

  // Set wins over a same-cycle clear
  assign flag_next = hit_i || (flag_o && !clr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_next;
      irq_o  <= flag_next && ien_next_i;
    end
  end

  // R9: a terminal tick always leaves the flag set
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_i |=> flag_o);
  // R6: a clear without a coincident tick drops the flag
  p_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !hit_i) |=> !flag_o);
  // R5: interrupt only with flag and enable
  p_irq_gate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (flag_o && ien_i));
  // R5: flag and enable always raise the interrupt
  p_irq_follow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_o && ien_i) |-> irq_o);
endmodule

// File: rtl/pit_ms_timer.sv
module pit_ms_timer #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic cen, ien, ien_next, period_wr, clr, hit, flag;
  logic [PERIOD_W-1:0] period;

  pit_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .flag_i(flag),
    .cen_o(cen), .ien_o(ien), .ien_next_o(ien_next), .period_o(period),
    .period_wr_o(period_wr), .clr_o(clr), .rdata_o(rdata_o)
  );

  pit_count #(.PERIOD_W(PERIOD_W)) u_count (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .cen_i(cen),
    .period_i(period), .restart_i(period_wr), .hit_o(hit)
  );

  pit_event u_event (
    .clk_i(clk_i), .rst_i(rst_i), .hit_i(hit), .clr_i(clr),
    .ien_next_i(ien_next), .ien_i(ien), .flag_o(flag), .irq_o(irq_o)
  );
endmodule

// File: tb/pit_ms_timer_bench.sv
module pit_ms_timer_bench;
  localparam int unsigned ADDR_W = 2, DATA_W = 32, PERIOD_W = 16;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  logic rd_seen = 1'b0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pit_ms_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_pit_ms_timer (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data the cycle after a read strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, logic [DATA_W-1:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    idle();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_irq(logic exp, string tag);
    @(negedge clk);
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  // Status word codes: bit15 count enable, bit14 irq enable, bit13 flag
  localparam logic [DATA_W-1:0] S_CE = 32'h8000, S_IE = 32'h4000, S_EV = 32'h2000;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R1 irq after reset");
    rd(0, 0, "R1 status after reset");
    rd(1, 0, "R1 period after reset");

    wr(1, 32'd4);
    rd(1, 32'd4, "R2 period readback");
    wr(0, S_CE | S_IE);
    ticks(3);
    rd(0, S_CE | S_IE, "R3 no flag before 4th tick");
    chk_irq(1'b0, "R5 irq low without flag");
    ticks(1);
    rd(0, S_CE | S_IE | S_EV, "R3 flag on 4th tick");
    chk_irq(1'b1, "R5 irq high with flag and enable");

    wr(0, S_CE | S_IE);
    rd(0, S_CE | S_IE | S_EV, "R6 zero write keeps flag");
    chk_irq(1'b1, "R5 irq held until clear");
    wr(0, S_CE | S_IE | S_EV);
    rd(0, S_CE | S_IE, "R6 one write clears flag");
    chk_irq(1'b0, "R5 irq low after clear");
    ticks(3);
    rd(0, S_CE | S_IE, "R3 restart: no flag after 3 more");
    ticks(1);
    rd(0, S_CE | S_IE | S_EV, "R3 second event 4 ticks later");
    wr(0, S_CE | S_IE | S_EV);

    ticks(2);
    wr(0, S_IE);
    ticks(10);
    rd(0, S_IE, "R4 ticks ignored while disabled");
    wr(0, S_CE | S_IE);
    ticks(1);
    rd(0, S_CE | S_IE, "R4 count held (3 of 4)");
    ticks(1);
    rd(0, S_CE | S_IE | S_EV, "R4 resume completes period");
    wr(0, S_CE | S_IE | S_EV);

    ticks(3);
    wr(1, 32'd4);
    ticks(3);
    rd(0, S_CE | S_IE, "R7 period write restarted count");
    ticks(1);
    rd(0, S_CE | S_IE | S_EV, "R7 full interval after write");
    wr(0, S_CE | S_IE | S_EV);

    wr(0, S_CE);
    ticks(4);
    rd(0, S_CE | S_EV, "R5 flag sets with irq disabled");
    chk_irq(1'b0, "R5 irq masked");
    wr(0, S_CE | S_IE);
    chk_irq(1'b1, "R5 irq on enabling with pending flag");
    wr(0, S_CE | S_IE | S_EV);

    ticks(3);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 0; wdata = S_CE | S_IE | S_EV;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(0, S_CE | S_IE | S_EV, "R9 set beats same-cycle clear");
    chk_irq(1'b1, "R9 irq after collision");
    wr(0, S_CE | S_IE | S_EV);

    wr(1, 32'd1);
    ticks(1);
    rd(0, S_CE | S_IE | S_EV, "R10 period 1 first tick");
    wr(0, S_CE | S_IE | S_EV);
    ticks(1);
    rd(0, S_CE | S_IE | S_EV, "R10 period 1 every tick");
    wr(0, S_CE | S_IE | S_EV);

    wr(1, 32'd0);
    ticks(6);
    rd(0, S_CE | S_IE, "R8 zero period never flags");
    chk_irq(1'b0, "R8 irq stays low");
    rd(1, 0, "R8 period reads zero");

    wr(1, 32'h0000_FFFF);
    rd(1, 32'h0000_FFFF, "R2 all-ones period");
    wr(1, 32'hABC1_2345);
    rd(1, 32'h0000_2345, "R2 upper bits dropped");

    repeat (3) idle();
    if (exp_q.size() != 0) check("R2 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule